// File: doc/BRIEF.md
# Masked Control Register Bank

This block is the 32-bit control and status register file of a host-bridge system controller. A processor reaches it through a simple single-cycle port. Each access carries a word index, which is the byte offset within the controller's 4 KB window divided by four, together with write data, a write strobe and a read strobe. Read data comes out of a register one cycle after the read strobe.

Each mapped word has its own write policy:

- Some words are fully writable.
- Some keep only the bits that a fixed mask selects.
- Error-report and ECC words ignore writes and always return their reset contents.
- The two synchronisation-barrier words return a fixed marker on every read.

The configuration data word is a plain scratch register. A build-time endianness parameter sets the reset values of the CPU configuration word and the command words. The same parameter byte-reverses all read data for a big-endian host.

Top module: `regbank_ctrl`

## Requirements
- R1: Only these word indices are mapped: 0x000 (CPU configuration), 0x010/0x011 (command A/B), 0x020 (configuration address), 0x021 (configuration data), 0x030-0x033 (memory bank parameters 0-3), 0x040-0x044 (error report: address low, address high, data low, data high, parity), 0x050-0x054 (ECC), 0x060/0x061 (sync barriers). A read of any other index returns 0.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` is loaded only then and otherwise holds its value.
- R3: A write to command A or B stores `wdata & 0x0401FC0F`.
- R4: A write to the configuration address word stores `wdata & 0x80FFFFFC`.
- R5: The CPU configuration word and the configuration data word store all 32 written bits.
- R6: The four memory bank parameter words store any value, read back the last value written, and reset to 0x00000005.
- R7: The error-report words ignore writes and always read 0x00000000, 0x00000000, 0xFFFFFFFF, 0xFFFFFFFF and 0x000000FF, in index order.
- R8: The five ECC words ignore writes and always read 0.
- R9: Both sync-barrier words read 0xC000FFEE and ignore writes.
- R10: With `BIG_ENDIAN`=0, reset sets CPU configuration to 0x00000800 and both command words to 0x00010001. With `BIG_ENDIAN`=1, all three reset to 0. The configuration address and data words reset to 0. A synchronous reset during operation restores every reset value.
- R11: With `BIG_ENDIAN`=1, every read returns the stored or fixed word with its bytes reversed, so byte 0 moves to bits 31:24. Masks apply to `wdata` as written.
- R12: A write to an unmapped index has no effect on any register.
- R13: A read and a write to the same index in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| word_idx | input | 10 | Word index (byte offset bits 11:2) |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle `rd_data` holds a fresh read |

## Verification
The assertions check the following on every clock:

- the read-strobe-to-valid timing, and that read data holds between reads;
- that no write enables more than one storage slot, and that a cycle without a write enables none;
- that sync, parity and ECC reads return their fixed words, reversed in big-endian mode;
- that the command mask never leaks a cleared bit into read data;
- that unmapped reads return zero.

Only the bench scenarios can show what a write actually does: mask effects on the configuration address word, last-value-written behaviour, read-before-write in a shared cycle, and restoration of reset values after a reset in mid-run. They compare a little-endian and a big-endian instance against a behavioural model on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int WIN_W   = 12;
    localparam int IDX_W   = WIN_W - 2;
    localparam int DATA_W  = 32;
    localparam int N_SDRAM = 4;
    localparam int N_ERR   = 5;
    localparam int N_ECC   = 5;
    localparam int N_SYNC  = 2;
    localparam int N_FIXED_SLOTS = 5;
    localparam int N_SLOT  = N_FIXED_SLOTS + N_SDRAM;
    localparam int SLOT_W  = $clog2(N_SLOT);

    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam widx_t IDX_CPU_CFG  = 10'h000;
    localparam widx_t IDX_CMD_A    = 10'h010;
    localparam widx_t IDX_CMD_B    = 10'h011;
    localparam widx_t IDX_CFG_ADDR = 10'h020;
    localparam widx_t IDX_CFG_DATA = 10'h021;
    localparam widx_t IDX_BANK0    = 10'h030;
    localparam widx_t IDX_ERR0     = 10'h040;
    localparam widx_t IDX_ECC0     = 10'h050;
    localparam widx_t IDX_SYNC0    = 10'h060;

    localparam word_t CMD_MASK   = 32'h0401_FC0F;
    localparam word_t CFGA_MASK  = 32'h80FF_FFFC;
    localparam word_t SYNC_WORD  = 32'hC000_FFEE;
    localparam word_t BANK_RESET = 32'h0000_0005;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_STORED,
        RD_CONST
    } rd_src_e;

    typedef struct packed {
        rd_src_e           src;
        logic [SLOT_W-1:0] slot;
        word_t             konst;
    } rd_sel_t;

    function automatic widx_t slot_idx(input int s);
        case (s)
            0:       return IDX_CPU_CFG;
            1:       return IDX_CMD_A;
            2:       return IDX_CMD_B;
            3:       return IDX_CFG_ADDR;
            4:       return IDX_CFG_DATA;
            default: return widx_t'(int'(IDX_BANK0) + s - N_FIXED_SLOTS);
        endcase
    endfunction

    function automatic word_t slot_mask(input int s);
        case (s)
            1, 2:    return CMD_MASK;
            3:       return CFGA_MASK;
            default: return '1;
        endcase
    endfunction

    function automatic word_t slot_reset(input int s, input bit be);
        case (s)
            0:       return be ? 32'h0 : 32'h0000_0800;
            1, 2:    return be ? 32'h0 : 32'h0001_0001;
            3, 4:    return 32'h0;
            default: return BANK_RESET;
        endcase
    endfunction

    function automatic word_t err_value(input int k);
        case (k)
            2, 3:    return 32'hFFFF_FFFF;
            4:       return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic word_t byte_rev(input word_t w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic word_t host_order(input word_t w, input bit be);
        return be ? byte_rev(w) : w;
    endfunction

    function automatic bit in_range(input widx_t i, input widx_t base, input int n);
        return (int'(i) >= int'(base)) && (int'(i) < int'(base) + n);
    endfunction

    function automatic bit is_mapped(input widx_t i);
        return (i == IDX_CPU_CFG) || (i == IDX_CMD_A) || (i == IDX_CMD_B) ||
               (i == IDX_CFG_ADDR) || (i == IDX_CFG_DATA) ||
               in_range(i, IDX_BANK0, N_SDRAM) || in_range(i, IDX_ERR0, N_ERR) ||
               in_range(i, IDX_ECC0, N_ECC) || in_range(i, IDX_SYNC0, N_SYNC);
    endfunction

endpackage

// File: rtl/regbank_wdec.sv
module regbank_wdec
    import regbank_pkg::*;
(
    input  logic              wr_en,
    input  widx_t             word_idx,
    output logic [N_SLOT-1:0] wr_hit
);
    for (genvar s = 0; s < N_SLOT; s++) begin : g_hit
        assign wr_hit[s] = wr_en && (word_idx == slot_idx(s));
    end
endmodule

// File: rtl/regbank_slots.sv
module regbank_slots
    import regbank_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_SLOT-1:0]             wr_hit,
    input  word_t                         wdata,
    output logic [N_SLOT-1:0][DATA_W-1:0] slot_q
);
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        localparam word_t MASK  = slot_mask(s);
        localparam word_t RESET = slot_reset(s, BIG_ENDIAN);
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= RESET;
            end else if (wr_hit[s]) begin
                slot_q[s] <= wdata & MASK;
            end
        end
    end
endmodule

// File: rtl/regbank_rdpath.sv
module regbank_rdpath
    import regbank_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  widx_t                         word_idx,
    input  logic [N_SLOT-1:0][DATA_W-1:0] slot_q,
    output word_t                         rd_data,
    output logic                          rd_valid
);
    rd_sel_t sel;
    word_t   raw;
    word_t   host_word;

    always_comb begin
        sel = '{src: RD_ZERO, slot: '0, konst: '0};
        for (int s = 0; s < N_SLOT; s++) begin
            if (word_idx == slot_idx(s)) begin
                sel.src  = RD_STORED;
                sel.slot = SLOT_W'(s);
            end
        end
        for (int k = 0; k < N_ERR; k++) begin
            if (word_idx == widx_t'(int'(IDX_ERR0) + k)) begin
                sel.src   = RD_CONST;
                sel.konst = err_value(k);
            end
        end
        for (int k = 0; k < N_ECC; k++) begin
            if (word_idx == widx_t'(int'(IDX_ECC0) + k)) begin
                sel.src   = RD_CONST;
                sel.konst = '0;
            end
        end
        for (int k = 0; k < N_SYNC; k++) begin
            if (word_idx == widx_t'(int'(IDX_SYNC0) + k)) begin
                sel.src   = RD_CONST;
                sel.konst = SYNC_WORD;
            end
        end
    end

    always_comb begin
        case (sel.src)
            RD_STORED: raw = slot_q[sel.slot];
            RD_CONST:  raw = sel.konst;
            default:   raw = '0;
        endcase
    end

    if (BIG_ENDIAN) begin : g_swap
        assign host_word = byte_rev(raw);
    end else begin : g_pass
        assign host_word = raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= host_word;
            end
        end
    end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
    import regbank_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [N_SLOT-1:0]             wr_hit;
    logic [N_SLOT-1:0][DATA_W-1:0] slot_q;

    regbank_wdec u_wdec (
        .wr_en    (wr_en),
        .word_idx (word_idx),
        .wr_hit   (wr_hit)
    );

    regbank_slots #(.BIG_ENDIAN(BIG_ENDIAN)) u_slots (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wdata  (wdata),
        .slot_q (slot_q)
    );

    regbank_rdpath #(.BIG_ENDIAN(BIG_ENDIAN)) u_rdpath (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .word_idx (word_idx),
        .slot_q   (slot_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/regbank_ctrl_chk.sv
module regbank_ctrl_chk
    import regbank_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [IDX_W-1:0]  word_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [N_SLOT-1:0] wr_hit
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_single_slot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit));

    p_idle_no_write_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (wr_hit == '0));

    p_cmd_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (word_idx == IDX_CMD_A || word_idx == IDX_CMD_B)) |=>
        ((host_order(rd_data, BIG_ENDIAN) & ~CMD_MASK) == '0));

    p_sync_marker_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && in_range(word_idx, IDX_SYNC0, N_SYNC)) |=>
        (rd_data == host_order(SYNC_WORD, BIG_ENDIAN)));

    p_parity_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && word_idx == widx_t'(int'(IDX_ERR0) + 4)) |=>
        (rd_data == host_order(32'h0000_00FF, BIG_ENDIAN)));

    p_ecc_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && in_range(word_idx, IDX_ECC0, N_ECC)) |=> (rd_data == '0));

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !is_mapped(word_idx)) |=> (rd_data == '0));
endmodule

bind regbank_ctrl regbank_ctrl_chk #(.BIG_ENDIAN(BIG_ENDIAN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .word_idx (word_idx),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .wr_hit   (wr_hit)
);

// File: tb/regbank_ctrl_tb.sv
module regbank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  word_idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_le, rd_be;
    logic        v_le, v_be;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    string cur_req = "R10";
    bit started = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regbank_ctrl #(.BIG_ENDIAN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .word_idx(word_idx), .wdata(wdata), .rd_data(rd_le), .rd_valid(v_le));

    regbank_ctrl #(.BIG_ENDIAN(1'b1)) u_dut_be (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .word_idx(word_idx), .wdata(wdata), .rd_data(rd_be), .rd_valid(v_be));

    // Behavioural reference: stored words per endianness, keyed by index
    logic [31:0] st_le[int];
    logic [31:0] st_be[int];
    logic [31:0] exp_le = '0, exp_be = '0;
    bit          exp_v = 1'b0;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic model_reset();
        st_le.delete();
        st_be.delete();
        st_le['h000] = 32'h800;     st_be['h000] = 0;
        st_le['h010] = 32'h10001;   st_be['h010] = 0;
        st_le['h011] = 32'h10001;   st_be['h011] = 0;
        st_le['h020] = 0;           st_be['h020] = 0;
        st_le['h021] = 0;           st_be['h021] = 0;
        for (int i = 'h030; i <= 'h033; i++) begin
            st_le[i] = 5;
            st_be[i] = 5;
        end
    endtask

    function automatic logic [31:0] model_read(input bit be, input int idx);
        logic [31:0] w;
        if (be ? st_be.exists(idx) : st_le.exists(idx)) w = be ? st_be[idx] : st_le[idx];
        else if (idx == 'h042 || idx == 'h043) w = 32'hFFFFFFFF;
        else if (idx == 'h044) w = 32'hFF;
        else if (idx == 'h060 || idx == 'h061) w = 32'hC000FFEE;
        else w = 0;
        return be ? swap32(w) : w;
    endfunction

    task automatic model_write(input int idx, input logic [31:0] d);
        logic [31:0] m;
        if (idx == 'h010 || idx == 'h011) m = 32'h0401FC0F;
        else if (idx == 'h020) m = 32'h80FFFFFC;
        else m = 32'hFFFFFFFF;
        if (st_le.exists(idx)) begin
            st_le[idx] = d & m;
            st_be[idx] = d & m;
        end
    endtask

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            model_reset();
            exp_le = 0;
            exp_be = 0;
            exp_v  = 0;
        end else begin
            exp_v = rd_en;
            if (rd_en) begin
                exp_le = model_read(1'b0, int'(word_idx));
                exp_be = model_read(1'b1, int'(word_idx));
            end
            if (wr_en) model_write(int'(word_idx), wdata);
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (started && !done) begin
            n_checks++;
            if (rd_le !== exp_le || v_le !== exp_v) begin
                n_errors++;
                $display("FAIL %s: LE rd_data=%h valid=%b, expected %h valid=%b",
                         cur_req, rd_le, v_le, exp_le, exp_v);
            end
            n_checks++;
            if (rd_be !== exp_be || v_be !== exp_v) begin
                n_errors++;
                $display("FAIL R11 (%s): BE rd_data=%h valid=%b, expected %h valid=%b",
                         cur_req, rd_be, v_be, exp_be, exp_v);
            end
        end
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run still active at %0d cycles, expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic op(input bit w, input bit r, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = w;
        rd_en = r;
        word_idx = idx[9:0];
        wdata = d;
    endtask

    task automatic rd(input int idx);
        op(0, 1, idx, 32'h0);
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        op(1, 0, idx, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, 0, 32'h0);
    endtask

    initial begin
        // R10: reset values, both endianness variants
        cur_req = "R10";
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        rd('h000); rd('h010); rd('h011); rd('h020); rd('h021); idle(2);

        // R6: bank parameters reset and read-back
        cur_req = "R6";
        for (int i = 'h030; i <= 'h033; i++) rd(i);
        for (int i = 'h030; i <= 'h033; i++) wr(i, 32'h1234_5600 + i);
        for (int i = 'h033; i >= 'h030; i--) rd(i);
        wr('h031, 32'hDEAD_BEEF); rd('h031); rd('h030); idle(1);

        // R3: command mask
        cur_req = "R3";
        wr('h010, 32'hFFFF_FFFF); rd('h010);
        wr('h011, 32'hA5A5_A5A5); rd('h011);
        wr('h011, 32'h0000_0000); rd('h011); rd('h010); idle(1);

        // R4: configuration address mask
        cur_req = "R4";
        wr('h020, 32'hFFFF_FFFF); rd('h020);
        wr('h020, 32'h7F00_0003); rd('h020); idle(1);

        // R5: fully writable words
        cur_req = "R5";
        wr('h021, 32'hCAFE_F00D); rd('h021);
        wr('h000, 32'h8765_4321); rd('h000); idle(1);

        // R7: error report words ignore writes
        cur_req = "R7";
        for (int i = 'h040; i <= 'h044; i++) wr(i, 32'h5A5A_5A5A);
        for (int i = 'h040; i <= 'h044; i++) rd(i);
        idle(1);

        // R8: ECC words ignore writes
        cur_req = "R8";
        for (int i = 'h050; i <= 'h054; i++) wr(i, 32'hFFFF_FFFF);
        for (int i = 'h050; i <= 'h054; i++) rd(i);
        idle(1);

        // R9: sync barrier marker
        cur_req = "R9";
        rd('h060); wr('h061, 32'h0); rd('h061); rd('h060); idle(1);

        // R1: neighbours of mapped words are unmapped
        cur_req = "R1";
        rd('h001); rd('h012); rd('h022); rd('h034); rd('h045);
        rd('h055); rd('h062); rd('h3FF); idle(1);

        // R12: unmapped writes change nothing
        cur_req = "R12";
        wr('h012, 32'hFFFF_FFFF); wr('h3FF, 32'h1111_1111); wr('h034, 32'h2222_2222);
        rd('h012); rd('h3FF); rd('h034); rd('h033); rd('h010); rd('h021); idle(1);

        // R13: read in the same cycle as a write sees the old value
        cur_req = "R13";
        op(1, 1, 'h032, 32'h0BAD_CAFE); rd('h032);
        op(1, 1, 'h010, 32'h0000_0000); rd('h010); idle(1);

        // R2: back-to-back reads, then idle holds data
        cur_req = "R2";
        rd('h021); rd('h060); rd('h042); idle(4); rd('h044); idle(3);

        // R10: mid-run reset restores every value
        cur_req = "R10";
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        @(negedge clk);
        rst = 1'b0;
        rd('h000); rd('h010); rd('h011); rd('h020); rd('h021);
        rd('h030); rd('h031); rd('h032); rd('h033); idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule